// File: doc/BRIEF.md
# Flat Pointer Aperture Classifier

This block sits behind the address stage of a shader memory pipe. Each request carries a flat pointer, the size of its payload in bytes and the addressing-mode controls of its process. The block decides where the request goes: on-chip shared memory, per-thread private scratch memory, or the external memory path. Requests for the external path leave in a compressed form, which is one translation-select bit plus a 48-bit address. Each result also carries a cache-policy type and a fault indication.

Three addressing modes exist:

- **Wide host mode.** Pointers are 64 bits wide. Addresses outside every aperture go to host translation.
- **Narrow host mode.** Only the low 32 bits of the pointer are used.
- **Device-table mode.** Pointers are 64 bits wide. Addresses outside every aperture go to the device page tables.

Four apertures are programmable: shared, private, device-table and spare. Each one is defined at 64KB granularity. In the 64-bit modes, addresses in the non-canonical middle of the address space are illegal unless an aperture claims them. A payload that crosses between regions is a fault.

Requests enter on a valid/ready handshake and results leave from a single output register. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result is visible from that edge. While `out_valid` is high and `out_ready` is low, every output holds still and no new request is taken. All configuration pins are plain level inputs, sampled together with the request.

Top module: `flat_ptr_router`

## Requirements
- R1: Mode decode. `mode_atc`=1 with `mode_ptr32`=0 selects wide host mode. `mode_atc`=1 with `mode_ptr32`=1 selects narrow host mode. `mode_atc`=0 selects device-table mode whatever `mode_ptr32` holds.
- R2: When `in_draw`=1, the request uses device-table mode regardless of `mode_atc` and `mode_ptr32`.
- R3: An aperture spans from {base_reg, 16'h0000} to {limit_reg, 16'hFFFF}, and both ends are inside it.
- R4: A hit in the device-table aperture gives target 0, `out_sel`=0, `out_addr` = pointer minus the aperture base (low 48 bits), and `out_type` = `default_type`.
- R5: An address outside every aperture gives target 0 with `out_type` = `default_type`:
  - Wide host mode: `out_sel`=1 and `out_addr` = pointer[47:0].
  - Device-table mode: `out_sel`=0 and `out_addr` = pointer[47:0].
  - Narrow host mode: `out_sel`=1 and `out_addr` = the low 32 bits, zero-extended.
- R6: In the 64-bit modes, an address whose bits [63:47] are neither all zero nor all one, and which lies in no aperture, is a fault.
- R7: The last byte is at pointer + `in_len` − 1, and a length of 0 counts as 1. It is a fault if the first and last bytes lie in different regions, or if that sum carries out of the pointer width (64 bits, or 32 bits in narrow mode).
- R8: A hit in the spare aperture gives target 0, the default translation select of the mode, `out_addr` = pointer[47:0] and `out_type` = `spare_type`. The spare aperture is ignored in narrow host mode.
- R9: Narrow host mode ignores pointer bits [63:32]. A shared or private base register whose bits [15:0] are zero disables that aperture. Otherwise the aperture runs from {bits[15:0], 16'h0000} to {bits[15:0], 16'hFFFF}, and the limit registers are unused.
- R10: A shared hit gives target 1 and a private hit gives target 2. In both cases `out_sel`=0, `out_addr` = the offset from the aperture base, and `out_type` = `default_type`.
- R11: A fault gives target 3, `out_sel`=0, `out_addr`=0 and `out_type`=0.
- R12: When apertures overlap, the priority is shared first, then private, then device-table, then spare.
- R13: `in_ready` = !`out_valid` || `out_ready`. A request accepted at an edge has its result on the outputs after that edge. The outputs are held stable while `out_valid` && !`out_ready`. After reset, `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_ptr | input | 64 | Flat pointer |
| in_len | input | 5 | Payload byte count |
| in_draw | input | 1 | Graphics-type request, forces device-table mode |
| mode_atc | input | 1 | Process default is host translation |
| mode_ptr32 | input | 1 | Process uses 32-bit pointers |
| shared_base_reg | input | 48 | Shared aperture base, address bits [63:16] |
| shared_limit_reg | input | 48 | Shared aperture limit, address bits [63:16] |
| private_base_reg | input | 48 | Private aperture base, address bits [63:16] |
| private_limit_reg | input | 48 | Private aperture limit, address bits [63:16] |
| gvm_base_reg | input | 48 | Device-table aperture base, address bits [63:16] |
| gvm_limit_reg | input | 48 | Device-table aperture limit, address bits [63:16] |
| spare_base_reg | input | 48 | Spare aperture base, address bits [63:16] |
| spare_limit_reg | input | 48 | Spare aperture limit, address bits [63:16] |
| spare_type | input | 2 | Cache-policy type for spare hits |
| default_type | input | 2 | Cache-policy type for all other non-fault results |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_target | output | 2 | 0 memory, 1 shared, 2 private, 3 fault |
| out_sel | output | 1 | Translation select: 1 host, 0 device tables |
| out_addr | output | 48 | Translated-form address or local offset |
| out_type | output | 2 | Cache-policy type |

## Verification
The assertions assume that the configuration pins are held steady while a request is accepted. The narrow-mode spare check also assumes that `spare_type` differs from `default_type`. The bench changes configuration only while `in_valid` is low and always programs two distinct type values. The handshake checks assume that `in_valid` drops only after acceptance, which every bench task respects because each task waits for the accepting edge before it releases the request.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int VA_W    = 48;
  localparam int TYPE_W  = 2;
  localparam int NUM_APE = 4;
  localparam int APE_SH  = 0;
  localparam int APE_PR  = 1;
  localparam int APE_GV  = 2;
  localparam int APE_SP  = 3;

  typedef enum logic [1:0] {MODE_HOST64, MODE_HOST32, MODE_DEV64} mode_e;
  typedef enum logic [1:0] {TGT_MEM = 2'd0, TGT_SHARED = 2'd1,
                            TGT_PRIVATE = 2'd2, TGT_FAULT = 2'd3} tgt_e;
  // region code = aperture index + 1, 0 = no aperture
  typedef enum logic [2:0] {RG_NONE = 3'd0, RG_SHARED = 3'd1, RG_PRIVATE = 3'd2,
                            RG_DEV = 3'd3, RG_SPARE = 3'd4} region_e;

  typedef struct packed {
    tgt_e              tgt;
    logic              sel;
    logic [VA_W-1:0]   addr;
    logic [TYPE_W-1:0] ptype;
  } result_t;
endpackage

// File: rtl/fpc_range_chk.sv
module fpc_range_chk #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          en,
  output logic          hit
);
  assign hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/fpc_region_sel.sv
module fpc_region_sel import fpc_pkg::*; (
  input  logic [NUM_APE-1:0] hit,
  output region_e            rg
);
  // lowest index wins: scan from the lowest priority upwards
  always_comb begin
    rg = RG_NONE;
    for (int a = NUM_APE - 1; a >= 0; a--) begin
      if (hit[a]) rg = region_e'(a + 1);
    end
  end
endmodule

// File: rtl/fpc_shape.sv
module fpc_shape import fpc_pkg::*; #(
  parameter int PTR_W = 64
) (
  input  mode_e             mode,
  input  region_e           rg_first,
  input  region_e           rg_last,
  input  logic              hole_first,
  input  logic              hole_last,
  input  logic              carry,
  input  logic [PTR_W-1:0]  first,
  input  logic [PTR_W-1:0]  sh_base,
  input  logic [PTR_W-1:0]  pr_base,
  input  logic [PTR_W-1:0]  dv_base,
  input  logic [TYPE_W-1:0] spare_type,
  input  logic [TYPE_W-1:0] default_type,
  output result_t           res
);
  logic             viol;
  logic             dflt_sel;
  logic [PTR_W-1:0] off_sh, off_pr, off_dv;

  assign dflt_sel = (mode != MODE_DEV64);
  assign off_sh   = first - sh_base;
  assign off_pr   = first - pr_base;
  assign off_dv   = first - dv_base;
  assign viol     = carry || (rg_first != rg_last) ||
                    (rg_first == RG_NONE && hole_first) ||
                    (rg_last  == RG_NONE && hole_last);

  always_comb begin
    res = '0;
    if (viol) begin
      res.tgt = TGT_FAULT;
    end else begin
      res.ptype = default_type;
      unique case (rg_first)
        RG_SHARED: begin
          res.tgt  = TGT_SHARED;
          res.addr = off_sh[VA_W-1:0];
        end
        RG_PRIVATE: begin
          res.tgt  = TGT_PRIVATE;
          res.addr = off_pr[VA_W-1:0];
        end
        RG_DEV: begin
          res.tgt  = TGT_MEM;
          res.addr = off_dv[VA_W-1:0];
        end
        RG_SPARE: begin
          res.tgt   = TGT_MEM;
          res.sel   = dflt_sel;
          res.addr  = first[VA_W-1:0];
          res.ptype = spare_type;
        end
        default: begin
          res.tgt  = TGT_MEM;
          res.sel  = dflt_sel;
          res.addr = first[VA_W-1:0];
        end
      endcase
    end
  end
endmodule

// File: rtl/fpc_out_stage.sv
module fpc_out_stage import fpc_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  result_t in_res,
  output logic    out_valid,
  input  logic    out_ready,
  output result_t out_res
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_res <= in_res;
    end
  end

  // R13
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));
  // R13
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R11
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_res.tgt == TGT_FAULT |->
      out_res.addr == '0 && out_res.ptype == '0 && !out_res.sel);
endmodule

// File: rtl/flat_ptr_router.sv
module flat_ptr_router import fpc_pkg::*; #(
  parameter  int PTR_W    = 64,
  parameter  int NARROW_W = 32,
  parameter  int GRAN_W   = 16,
  parameter  int LEN_W    = 5,
  localparam int REG_W    = PTR_W - GRAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PTR_W-1:0]  in_ptr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_draw,
  input  logic              mode_atc,
  input  logic              mode_ptr32,
  input  logic [REG_W-1:0]  shared_base_reg,
  input  logic [REG_W-1:0]  shared_limit_reg,
  input  logic [REG_W-1:0]  private_base_reg,
  input  logic [REG_W-1:0]  private_limit_reg,
  input  logic [REG_W-1:0]  gvm_base_reg,
  input  logic [REG_W-1:0]  gvm_limit_reg,
  input  logic [REG_W-1:0]  spare_base_reg,
  input  logic [REG_W-1:0]  spare_limit_reg,
  input  logic [TYPE_W-1:0] spare_type,
  input  logic [TYPE_W-1:0] default_type,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_target,
  output logic              out_sel,
  output logic [VA_W-1:0]   out_addr,
  output logic [TYPE_W-1:0] out_type
);
  localparam int NSEL_W = NARROW_W - GRAN_W;
  localparam int NUM_EP = 2;

  mode_e            mode;
  logic             narrow;
  logic [PTR_W-1:0] ptr_eff, last_eff;
  logic [PTR_W:0]   sum;
  logic [LEN_W-1:0] len_m1;
  logic             carry;

  // mode decode
  always_comb begin
    if (in_draw || !mode_atc) mode = MODE_DEV64;
    else if (mode_ptr32)      mode = MODE_HOST32;
    else                      mode = MODE_HOST64;
  end
  assign narrow   = (mode == MODE_HOST32);
  assign ptr_eff  = narrow ? PTR_W'(in_ptr[NARROW_W-1:0]) : in_ptr;
  assign len_m1   = (in_len == '0) ? '0 : in_len - 1'b1;
  assign sum      = {1'b0, ptr_eff} + (PTR_W+1)'(len_m1);
  assign carry    = narrow ? sum[NARROW_W] : sum[PTR_W];
  assign last_eff = sum[PTR_W-1:0];

  // aperture bounds
  logic [REG_W-1:0] reg_lo [NUM_APE];
  logic [REG_W-1:0] reg_hi [NUM_APE];
  logic [PTR_W-1:0] ape_lo [NUM_APE];
  logic [PTR_W-1:0] ape_hi [NUM_APE];
  logic [NUM_APE-1:0] ape_en;

  assign reg_lo[APE_SH] = shared_base_reg;
  assign reg_hi[APE_SH] = shared_limit_reg;
  assign reg_lo[APE_PR] = private_base_reg;
  assign reg_hi[APE_PR] = private_limit_reg;
  assign reg_lo[APE_GV] = gvm_base_reg;
  assign reg_hi[APE_GV] = gvm_limit_reg;
  assign reg_lo[APE_SP] = spare_base_reg;
  assign reg_hi[APE_SP] = spare_limit_reg;

  always_comb begin
    for (int a = 0; a < NUM_APE; a++) begin
      ape_lo[a] = {reg_lo[a], {GRAN_W{1'b0}}};
      ape_hi[a] = {reg_hi[a], {GRAN_W{1'b1}}};
      ape_en[a] = 1'b1;
    end
    if (narrow) begin
      for (int a = APE_SH; a <= APE_PR; a++) begin
        ape_lo[a] = PTR_W'({reg_lo[a][NSEL_W-1:0], {GRAN_W{1'b0}}});
        ape_hi[a] = PTR_W'({reg_lo[a][NSEL_W-1:0], {GRAN_W{1'b1}}});
        ape_en[a] = |reg_lo[a][NSEL_W-1:0];
      end
      ape_en[APE_SP] = 1'b0;
    end
  end

  // per-endpoint matching
  logic [PTR_W-1:0]          ep_addr [NUM_EP];
  logic [NUM_EP*NUM_APE-1:0] ep_hit;
  logic [NUM_EP-1:0]         ep_hole;
  region_e                   ep_rg   [NUM_EP];

  assign ep_addr[0] = ptr_eff;
  assign ep_addr[1] = last_eff;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    for (genvar a = 0; a < NUM_APE; a++) begin : g_ape
      fpc_range_chk #(.AW(PTR_W)) u_chk (
        .addr (ep_addr[e]),
        .lo   (ape_lo[a]),
        .hi   (ape_hi[a]),
        .en   (ape_en[a]),
        .hit  (ep_hit[e*NUM_APE + a])
      );
    end
    fpc_region_sel u_sel (
      .hit (ep_hit[e*NUM_APE +: NUM_APE]),
      .rg  (ep_rg[e])
    );
    assign ep_hole[e] = !narrow && !((&ep_addr[e][PTR_W-1:VA_W-1]) ||
                                     (~|ep_addr[e][PTR_W-1:VA_W-1]));
  end

  result_t res_d, res_q;

  fpc_shape #(.PTR_W(PTR_W)) u_shape (
    .mode         (mode),
    .rg_first     (ep_rg[0]),
    .rg_last      (ep_rg[1]),
    .hole_first   (ep_hole[0]),
    .hole_last    (ep_hole[1]),
    .carry        (carry),
    .first        (ptr_eff),
    .sh_base      (ape_lo[APE_SH]),
    .pr_base      (ape_lo[APE_PR]),
    .dv_base      (ape_lo[APE_GV]),
    .spare_type   (spare_type),
    .default_type (default_type),
    .res          (res_d)
  );

  fpc_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (res_q)
  );

  assign out_target = res_q.tgt;
  assign out_sel    = res_q.sel;
  assign out_addr   = res_q.addr;
  assign out_type   = res_q.ptype;

  // R10
  local_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_target == TGT_SHARED || out_target == TGT_PRIVATE) |-> !out_sel);
  // R2
  draw_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_draw |=> !out_sel);
  // R8
  narrow_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode_atc && mode_ptr32 && !in_draw &&
    spare_type != default_type |=> out_type != spare_type);
  // R13
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/sim_flat_ptr_router.sv
module sim_flat_ptr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_ptr = '0;
  logic [4:0]  in_len = '0;
  logic        in_draw = 1'b0, mode_atc = 1'b0, mode_ptr32 = 1'b0;
  logic [47:0] sh_lo, sh_hi, pr_lo, pr_hi, dv_lo, dv_hi, sp_lo, sp_hi;
  logic [1:0]  spare_type = 2'd2, default_type = 2'd1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_target;
  logic        out_sel;
  logic [47:0] out_addr;
  logic [1:0]  out_type;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flat_ptr_router u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ptr(in_ptr), .in_len(in_len), .in_draw(in_draw),
    .mode_atc(mode_atc), .mode_ptr32(mode_ptr32),
    .shared_base_reg(sh_lo), .shared_limit_reg(sh_hi),
    .private_base_reg(pr_lo), .private_limit_reg(pr_hi),
    .gvm_base_reg(dv_lo), .gvm_limit_reg(dv_hi),
    .spare_base_reg(sp_lo), .spare_limit_reg(sp_hi),
    .spare_type(spare_type), .default_type(default_type),
    .out_valid(out_valid), .out_ready(out_ready), .out_target(out_target),
    .out_sel(out_sel), .out_addr(out_addr), .out_type(out_type)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // packed result {target, sel, addr, type}
  function automatic logic [52:0] pk(input logic [1:0] t, input logic s,
                                     input logic [47:0] a, input logic [1:0] ty);
    return {t, s, a, ty};
  endfunction

  task automatic cfg_wide();
    sh_lo = 48'h2000_0000_0000; sh_hi = 48'h2000_0000_FFFF;
    pr_lo = 48'h2000_0001_0000; pr_hi = 48'h2000_0001_FFFF;
    dv_lo = 48'h1000_0000_0000; dv_hi = 48'h1000_00FF_FFFF;
    sp_lo = 48'h0000_1000_0000; sp_hi = 48'h0000_10FF_FFFF;
  endtask

  // one request with a given mode; result sampled at the following negedge
  task automatic send(input logic [63:0] p, input logic [4:0] n,
                      input logic drw, input logic atc, input logic p32);
    @(negedge clk);
    in_ptr = p; in_len = n; in_draw = drw; mode_atc = atc; mode_ptr32 = p32;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [52:0] exp);
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, {11'd0, out_target, out_sel, out_addr, out_type}, {11'd0, exp});
  endtask

  // independent priority model over wide-mode bounds (R12)
  function automatic logic [1:0] ref_target(input logic [63:0] a);
    if (a >= {sh_lo, 16'h0} && a <= {sh_hi, 16'hFFFF}) return 2'd1;
    if (a >= {pr_lo, 16'h0} && a <= {pr_hi, 16'hFFFF}) return 2'd2;
    return 2'd0;
  endfunction

  task automatic t_reset();
    chk("R13 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R13 reset in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_mode();
    send(64'hFFFF_8000_0000_0010, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R1 host64 default", pk(2'd0, 1'b1, 48'h8000_0000_0010, 2'd1));
    send(64'hFFFF_8000_0000_0010, 5'd4, 1'b0, 1'b0, 1'b1);
    expect_res("R1 dev64 ignores ptr32", pk(2'd0, 1'b0, 48'h8000_0000_0010, 2'd1));
    send(64'hFFFF_8000_0000_0010, 5'd4, 1'b0, 1'b1, 1'b1);
    expect_res("R1 host32 select", pk(2'd0, 1'b1, 48'h0000_0000_0010, 2'd1));
  endtask

  task automatic t_draw();
    send(64'hFFFF_8000_0000_0010, 5'd4, 1'b1, 1'b1, 1'b1);
    expect_res("R2 draw forces dev64", pk(2'd0, 1'b0, 48'h8000_0000_0010, 2'd1));
  endtask

  task automatic t_bounds();
    send(64'h1000_0000_0000_0000, 5'd1, 1'b0, 1'b1, 1'b0);
    expect_res("R3 base inclusive", pk(2'd0, 1'b0, 48'h0, 2'd1));
    send(64'h1000_00FF_FFFF_FFFF, 5'd1, 1'b0, 1'b1, 1'b0);
    expect_res("R3 limit inclusive", pk(2'd0, 1'b0, 48'h00FF_FFFF_FFFF, 2'd1));
    send(64'h1000_0100_0000_0000, 5'd1, 1'b0, 1'b1, 1'b0);
    expect_res("R3 R6 above limit in hole", pk(2'd3, 1'b0, 48'h0, 2'd0));
  endtask

  task automatic t_dev();
    send(64'h1000_0012_3456_0000, 5'd8, 1'b0, 1'b1, 1'b0);
    expect_res("R4 device-table offset", pk(2'd0, 1'b0, 48'h0012_3456_0000, 2'd1));
  endtask

  task automatic t_default();
    send(64'h0000_0000_1234_5678, 5'd4, 1'b0, 1'b0, 1'b0);
    expect_res("R5 dev64 default", pk(2'd0, 1'b0, 48'h0000_1234_5678, 2'd1));
    send(64'hDEAD_BEEF_0040_0000, 5'd4, 1'b0, 1'b1, 1'b1);
    expect_res("R5 host32 default", pk(2'd0, 1'b1, 48'h0000_0040_0000, 2'd1));
  endtask

  task automatic t_hole();
    send(64'h0FFF_FFFF_FFFF_FFFF, 5'd1, 1'b0, 1'b0, 1'b0);
    expect_res("R6 hole dev64", pk(2'd3, 1'b0, 48'h0, 2'd0));
    send(64'h0000_8000_0000_0000, 5'd1, 1'b0, 1'b1, 1'b0);
    expect_res("R6 hole just above low half", pk(2'd3, 1'b0, 48'h0, 2'd0));
  endtask

  task automatic t_straddle();
    send(64'h1000_00FF_FFFF_FFFC, 5'd8, 1'b0, 1'b1, 1'b0);
    expect_res("R7 R11 aperture to hole", pk(2'd3, 1'b0, 48'h0, 2'd0));
    send(64'h0000_10FF_FFFF_FFFE, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R7 spare to default", pk(2'd3, 1'b0, 48'h0, 2'd0));
    send(64'hFFFF_FFFF_FFFF_FFFE, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R7 carry 64", pk(2'd3, 1'b0, 48'h0, 2'd0));
    send(64'h0000_0000_FFFF_FFFE, 5'd4, 1'b0, 1'b1, 1'b1);
    expect_res("R7 carry 32", pk(2'd3, 1'b0, 48'h0, 2'd0));
    send(64'h1000_00FF_FFFF_FFFF, 5'd0, 1'b0, 1'b1, 1'b0);
    expect_res("R7 zero length as one", pk(2'd0, 1'b0, 48'h00FF_FFFF_FFFF, 2'd1));
  endtask

  task automatic t_spare();
    send(64'h0000_1000_0000_0100, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R8 spare type host64", pk(2'd0, 1'b1, 48'h1000_0000_0100, 2'd2));
    send(64'h0000_1000_0000_0100, 5'd4, 1'b0, 1'b0, 1'b0);
    expect_res("R8 spare type dev64", pk(2'd0, 1'b0, 48'h1000_0000_0100, 2'd2));
    sp_lo = 48'h0; sp_hi = 48'h0000_0000_FFFF;
    send(64'h0000_0000_0000_0100, 5'd4, 1'b0, 1'b1, 1'b1);
    expect_res("R8 spare ignored host32", pk(2'd0, 1'b1, 48'h0000_0000_0100, 2'd1));
    cfg_wide();
  endtask

  task automatic t_narrow_local();
    sh_lo = 48'h0000_0000_0003; pr_lo = 48'h0000_0000_0005;
    send(64'hABCD_0000_0003_0010, 5'd4, 1'b0, 1'b1, 1'b1);
    expect_res("R9 host32 shared", pk(2'd1, 1'b0, 48'h10, 2'd1));
    send(64'h0000_0000_0005_FFFF, 5'd1, 1'b0, 1'b1, 1'b1);
    expect_res("R9 host32 private top", pk(2'd2, 1'b0, 48'hFFFF, 2'd1));
    send(64'h0000_0000_0006_0000, 5'd1, 1'b0, 1'b1, 1'b1);
    expect_res("R9 host32 past 64KB", pk(2'd0, 1'b1, 48'h0006_0000, 2'd1));
    sh_lo = 48'h0;
    send(64'h0000_0000_0000_0010, 5'd4, 1'b0, 1'b1, 1'b1);
    expect_res("R9 zero base disabled", pk(2'd0, 1'b1, 48'h10, 2'd1));
    cfg_wide();
  endtask

  task automatic t_local64();
    send(64'h2000_0000_0000_1000, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R10 shared offset", pk(2'd1, 1'b0, 48'h1000, 2'd1));
    send(64'h2000_0001_0000_0020, 5'd4, 1'b0, 1'b0, 1'b0);
    expect_res("R10 private offset", pk(2'd2, 1'b0, 48'h20, 2'd1));
  endtask

  task automatic t_priority();
    dv_lo = 48'h2000_0000_0000; dv_hi = 48'h2000_0001_FFFF;
    sp_lo = dv_lo; sp_hi = dv_hi;
    send(64'h2000_0000_0000_0040, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R12 shared over device-table",
               pk(ref_target(64'h2000_0000_0000_0040), 1'b0, 48'h40, 2'd1));
    send(64'h2000_0001_0000_0040, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R12 private over device-table",
               pk(ref_target(64'h2000_0001_0000_0040), 1'b0, 48'h40, 2'd1));
    sh_lo = 48'h3000_0000_0000; sh_hi = 48'h3000_0000_FFFF;
    pr_lo = 48'h3000_0001_0000; pr_hi = 48'h3000_0001_FFFF;
    send(64'h2000_0000_0000_0040, 5'd4, 1'b0, 1'b1, 1'b0);
    expect_res("R12 device-table over spare",
               pk(ref_target(64'h2000_0000_0000_0040), 1'b0, 48'h40, 2'd1));
    cfg_wide();
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_ptr = 64'h2000_0000_0000_0100; in_len = 5'd4; in_draw = 1'b0;
    mode_atc = 1'b1; mode_ptr32 = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_ptr = 64'h0000_0000_0000_0200;
    chk("R13 stalled in_ready", {63'd0, in_ready}, 64'd0);
    expect_res("R13 first result", pk(2'd1, 1'b0, 48'h100, 2'd1));
    @(posedge clk);
    @(negedge clk);
    expect_res("R13 held while stalled", pk(2'd1, 1'b0, 48'h100, 2'd1));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    expect_res("R13 second after drain", pk(2'd0, 1'b1, 48'h200, 2'd1));
    @(posedge clk);
    @(negedge clk);
    chk("R13 empty after drain", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    cfg_wide();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mode();
    t_draw();
    t_bounds();
    t_dev();
    t_default();
    t_hole();
    t_straddle();
    t_spare();
    t_narrow_local();
    t_local64();
    t_priority();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule